// File: doc/BRIEF.md
# Serial Flash Page-Program Engine

This block is the receiving side of a serial flash device for one command: writing a page. A host drives clock, select and serial data in SPI mode 0 or mode 3. The block oversamples these lines with its own system clock. It collects an opcode, a 24-bit address and any number of data bytes into a 256-byte circular page buffer. When select goes high, it decides whether the frame may run.

An accepted frame starts a timed internal write. During that write the block merges the buffered bytes into a register-modelled array one byte per cycle. Because the merge is a bitwise AND, bits can only be cleared. A busy flag is raised for the whole operation. A one-cycle pulse asks the surrounding logic to drop the write-enable latch.

The array size (number of pages), the operation length and the opcode are parameters. A combinational read port exposes the array so that the stored contents can be inspected.

Top module: `pp_engine`

## Requirements
- R1: After reset, `wip` and `wel_clr` are 0 and every array byte reads 0xFF.
- R2: A program operation ANDs each new byte into the stored byte, so a stored 0 bit stays 0.
- R3: A frame ending while `wel` is 0 leaves the array unchanged and does not raise `wip`.
- R4: A valid frame is opcode 0x02 (first byte), then three address bytes (most significant first), then one or more data bytes. A frame with another opcode or with no data byte is ignored.
- R5: With N < 256 data bytes, byte k goes to page offset (start + k) mod 256, where start is the third address byte. Other offsets of the page are unchanged.
- R6: With N >= 256 data bytes, only the last 256 bytes are kept. Among them, the j-th oldest goes to page offset j.
- R7: A frame whose select rises when the count of sampled bits is not a multiple of 8 is ignored.
- R8: With select driven high between clock edges, `wip` becomes 1 after the third following rising clock edge and stays 1 for exactly PROG_CYCLES cycles. The array changes only while `wip` is 1.
- R9: `wel_clr` is a single-cycle pulse in the first cycle that `wip` is 1.
- R10: A frame addressing a page whose bit in `page_prot` is 1 is ignored.
- R11: A frame whose select falls while `wip` is 1 is ignored, and the operation in progress is unaffected.
- R12: Bits are sampled on rising SCK edges while select is low. Both SCK idle levels (mode 0 and mode 3) work.
- R13: The page number is taken from the low log2(NPAGES) bits of the second address byte. Higher address bits are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck | input | 1 | Serial clock from host |
| cs_n | input | 1 | Active-low chip select |
| si | input | 1 | Serial data from host, MSB first |
| wel | input | 1 | Write-enable latch state |
| page_prot | input | NPAGES | Per-page protection, 1 = protected |
| rd_addr | input | log2(NPAGES)+8 | Array read address |
| rd_data | output | 8 | Array byte at `rd_addr` |
| wip | output | 1 | Write operation in progress |
| wel_clr | output | 1 | Pulse requesting write-enable latch clear |

## Verification
Short frames in both clock modes show whether bytes land at their requested offsets. One of these frames starts near the end of a page, which shows whether the offset wraps inside the page rather than moving to the next one. A 300-byte frame can only pass if earlier bytes are dropped and the last 256 are rebased to offset zero. A second write over already-programmed bytes separates an AND merge from an overwrite. Further frames each have exactly one defect (no write enable, a protected page, a wrong opcode, no data, a stray partial byte, a start during busy, or high address bits set), and each must leave the array and the busy flag exactly as the bench's model predicts.

// File: rtl/pp_engine.sv
module pp_engine #(
  parameter int NPAGES      = 4,
  parameter int PROG_CYCLES = 300,
  parameter logic [7:0] OPCODE = 8'h02,
  localparam int PAGE_W     = $clog2(NPAGES),
  localparam int AW         = PAGE_W + 8,
  localparam int CW         = $clog2(PROG_CYCLES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck,
  input  logic              cs_n,
  input  logic              si,
  input  logic              wel,
  input  logic [NPAGES-1:0] page_prot,
  input  logic [AW-1:0]     rd_addr,
  output logic [7:0]        rd_data,
  output logic              wip,
  output logic              wel_clr
);

  logic [1:0] sck_s, cs_s, si_s;
  logic       sck_q, cs_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sck_s <= '0; cs_s <= '1; si_s <= '0;
      sck_q <= 1'b0; cs_q <= 1'b1;
    end else begin
      sck_s <= {sck_s[0], sck};
      cs_s  <= {cs_s[0], cs_n};
      si_s  <= {si_s[0], si};
      sck_q <= sck_s[1];
      cs_q  <= cs_s[1];
    end

  wire cs_fall  = ~cs_s[1] & cs_q;
  wire cs_rise  = cs_s[1] & ~cs_q;
  wire bit_rise = ~cs_s[1] & sck_s[1] & ~sck_q;

  logic [2:0]        bitc;
  logic [6:0]        sh;
  logic [2:0]        hdr;
  logic [7:0]        cnt, ptr;
  logic [PAGE_W-1:0] pg;
  logic              op_ok, have_data, full, ign, busy;
  logic [255:0]      vmask;
  logic [7:0]        pbuf [256];
  logic [7:0]        mem  [NPAGES*256];
  logic [CW-1:0]     pcnt;
  logic [8:0]        idx;

  wire [7:0] byte_in   = {sh, si_s[1]};
  wire       byte_done = bit_rise & (bitc == 3'd7) & ~ign;
  wire       data_wr   = byte_done & (hdr == 3'd4);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      bitc <= '0; sh <= '0; hdr <= '0; cnt <= '0; ptr <= '0; pg <= '0;
      op_ok <= 1'b0; have_data <= 1'b0; full <= 1'b0; ign <= 1'b0;
      vmask <= '0;
    end else if (cs_fall) begin
      ign  <= busy;
      bitc <= '0;
      if (!busy) begin
        hdr <= '0; cnt <= '0; op_ok <= 1'b0;
        have_data <= 1'b0; full <= 1'b0; vmask <= '0;
      end
    end else if (bit_rise && !ign) begin
      bitc <= bitc + 3'd1;
      sh   <= {sh[5:0], si_s[1]};
      if (bitc == 3'd7) begin
        if (hdr != 3'd4) hdr <= hdr + 3'd1;
        case (hdr)
          3'd0: op_ok <= (byte_in == OPCODE);
          3'd2: pg    <= byte_in[PAGE_W-1:0];
          3'd3: ptr   <= byte_in;
          3'd4: begin
            vmask[ptr] <= 1'b1;
            ptr        <= ptr + 8'd1;
            cnt        <= cnt + 8'd1;
            have_data  <= 1'b1;
            if (cnt == 8'hFF) full <= 1'b1;
          end
          default: ;
        endcase
      end
    end

  always_ff @(posedge clk)
    if (data_wr) pbuf[ptr] <= byte_in;

  wire go = cs_rise & ~ign & ~busy & op_ok & (hdr == 3'd4) & have_data
          & (bitc == 3'd0) & wel & ~page_prot[pg];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      busy <= 1'b0; pcnt <= '0; idx <= '0; wel_clr <= 1'b0;
    end else begin
      wel_clr <= go;
      if (go) begin
        busy <= 1'b1;
        pcnt <= CW'(PROG_CYCLES - 1);
        idx  <= '0;
      end else if (busy) begin
        if (pcnt == '0) busy <= 1'b0;
        else            pcnt <= pcnt - 1'b1;
        if (!idx[8]) idx <= idx + 9'd1;
      end
    end

  wire [7:0]    src = full ? ptr + idx[7:0] : idx[7:0];
  wire [AW-1:0] tgt = {pg, idx[7:0]};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < NPAGES*256; i++) mem[i] <= 8'hFF;
    end else if (busy && !idx[8] && vmask[src]) begin
      mem[tgt] <= mem[tgt] & pbuf[src];
    end

  assign rd_data = mem[rd_addr];
  assign wip     = busy;

endmodule

// File: rtl/pp_engine_chk.sv
module pp_engine_chk #(
  parameter int PROG_CYCLES = 300,
  parameter int AW = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wel,
  input logic          wip,
  input logic          wel_clr,
  input logic [AW-1:0] rd_addr,
  input logic [7:0]    rd_data
);

  logic [31:0] run;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) run <= '0;
    else        run <= wip ? run + 32'd1 : 32'd0;

  p_clr_at_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wip) |-> wel_clr);

  p_clr_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wel_clr |=> !wel_clr);

  p_busy_length_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wip) |-> (run == PROG_CYCLES));

  p_only_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(rd_addr) |-> ((rd_data & ~$past(rd_data)) == 8'h00));

  p_idle_array_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!wip && !$past(wip) && $stable(rd_addr)) |-> $stable(rd_data));

  p_needs_wel_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wel_clr |-> $past(wel));

endmodule

bind pp_engine pp_engine_chk #(.PROG_CYCLES(PROG_CYCLES), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wel(wel), .wip(wip), .wel_clr(wel_clr),
  .rd_addr(rd_addr), .rd_data(rd_data)
);

// File: tb/sim_pp_engine.sv
module sim_pp_engine;
  localparam int NPAGES = 4;
  localparam int PROG   = 300;
  localparam int AW     = $clog2(NPAGES) + 8;

  logic clk = 0, rst_n = 0, sck = 0, cs_n = 1, si = 0, wel = 0;
  logic [NPAGES-1:0] page_prot = '0;
  logic [AW-1:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic wip, wel_clr;

  pp_engine #(.NPAGES(NPAGES), .PROG_CYCLES(PROG)) u0 (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .si(si), .wel(wel),
    .page_prot(page_prot), .rd_addr(rd_addr), .rd_data(rd_data),
    .wip(wip), .wel_clr(wel_clr));

  always #2 clk = ~clk;

  int nchk = 0, nfail = 0, edges = 0, S = -1000000, extra = 0;
  bit mon_on = 0, mode3 = 0, done = 0;
  logic [7:0] tx_q[$];
  logic [7:0] mm [NPAGES*256];

  always @(posedge clk) edges++;

  function automatic bit exp_wip();
    return edges >= S && edges < S + PROG;
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) if (mon_on) begin
    chk(wip === exp_wip(), "R8", "wip", int'(wip), int'(exp_wip()));
    chk(wel_clr === (edges == S), "R9", "wel_clr", int'(wel_clr), int'(edges == S));
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(logic b);
    if (mode3) begin sck = 0; si = b; tick(3); sck = 1; tick(3); end
    else       begin si = b; tick(3); sck = 1; tick(3); sck = 0; end
  endtask

  task automatic run_frame();
    bit busy_fall, ok;
    int n, st, pg;
    sck = mode3;
    tick(2);
    busy_fall = exp_wip();
    cs_n = 0;
    tick(3);
    foreach (tx_q[i]) for (int b = 7; b >= 0; b--) send_bit(tx_q[i][b]);
    for (int b = 0; b < extra; b++) send_bit(1'b1);
    tick(3);
    n  = tx_q.size() - 4;
    pg = (tx_q.size() > 2) ? int'(tx_q[2]) % NPAGES : 0;
    ok = !busy_fall && n >= 1 && tx_q[0] == 8'h02 && extra == 0 && wel && !page_prot[pg];
    cs_n = 1;
    if (ok) begin
      S  = edges + 3;
      st = tx_q[3];
      if (n >= 256) for (int j = 0; j < 256; j++) mm[pg*256+j] &= tx_q[4+n-256+j];
      else for (int k = 0; k < n; k++) mm[pg*256+(st+k)%256] &= tx_q[4+k];
    end
    tick(3);
    extra = 0;
  endtask

  task automatic mk(logic [7:0] op, logic [7:0] a2, logic [7:0] a1, logic [7:0] a0,
                    int n, int seed);
    tx_q = {op, a2, a1, a0};
    for (int i = 0; i < n; i++) tx_q.push_back(8'((i * 37 + seed) ^ (i >> 3)));
  endtask

  task automatic wait_idle();
    tick(2);
    while (exp_wip()) tick(1);
    tick(2);
  endtask

  task automatic check_page(int pg, string req);
    int bad = 0, fa = 0;
    logic [7:0] act = 0, ex = 0;
    for (int a = 0; a < 256; a++) begin
      rd_addr = AW'(pg*256 + a);
      #1;
      if (rd_data !== mm[pg*256+a]) begin
        if (bad == 0) begin fa = a; act = rd_data; ex = mm[pg*256+a]; end
        bad++;
      end
    end
    chk(bad == 0, req, $sformatf("page %0d offset %0h", pg, fa), int'(act), int'(ex));
    @(negedge clk);
  endtask

  initial begin
    #(4 * 190000);
    chk(0, "ALL", "watchdog", 0, 1);
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    for (int i = 0; i < NPAGES*256; i++) mm[i] = 8'hFF;
    tick(4);
    rst_n = 1;
    tick(2);
    mon_on = 1;
    chk(wip === 1'b0 && wel_clr === 1'b0, "R1", "outputs after reset", int'({wip, wel_clr}), 0);
    for (int p = 0; p < NPAGES; p++) check_page(p, "R1");

    wel = 1;
    mode3 = 0; mk(8'h02, 8'h00, 8'h00, 8'h10, 8, 5); run_frame(); wait_idle();
    check_page(0, "R5 R12 mode0");

    tx_q = {8'h02, 8'h00, 8'h00, 8'h10, 8'hF0, 8'h0F, 8'hAA, 8'h55, 8'hFF, 8'h00};
    run_frame(); wait_idle();
    check_page(0, "R2 and-merge");

    mode3 = 1; mk(8'h02, 8'h00, 8'h01, 8'hFC, 10, 9); run_frame(); wait_idle();
    check_page(1, "R5 wrap R12 mode3");

    mode3 = 0; mk(8'h02, 8'h00, 8'h02, 8'h40, 300, 3); run_frame(); wait_idle();
    check_page(2, "R6 last 256");

    wel = 0; mk(8'h02, 8'h00, 8'h03, 8'h00, 4, 1); run_frame(); wait_idle();
    check_page(3, "R3 no wel");
    wel = 1;

    page_prot = 4'b1000; mk(8'h02, 8'h00, 8'h03, 8'h00, 4, 2); run_frame(); wait_idle();
    check_page(3, "R10 protected");
    page_prot = '0;

    mk(8'h03, 8'h00, 8'h03, 8'h00, 4, 4); run_frame(); wait_idle();
    check_page(3, "R4 bad opcode");
    mk(8'h02, 8'h00, 8'h03, 8'h00, 0, 0); run_frame(); wait_idle();
    check_page(3, "R4 no data");

    mk(8'h02, 8'h00, 8'h03, 8'h00, 3, 6); extra = 3; run_frame(); wait_idle();
    check_page(3, "R7 partial byte");

    mk(8'h02, 8'h00, 8'h03, 8'h20, 4, 7); run_frame();
    tick(3);
    chk(exp_wip(), "R11", "first frame busy", 1, 1);
    mk(8'h02, 8'h00, 8'h03, 8'h80, 4, 11); run_frame(); wait_idle();
    check_page(3, "R11 during busy");

    mk(8'h02, 8'hFF, 8'hA5, 8'h80, 6, 13); run_frame(); wait_idle();
    check_page(1, "R13 page bits");
    check_page(0, "R13 other page");

    mon_on = 0;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule